// File: doc/BRIEF.md
# Capture/Compare Timer with Flags

This block is a 16-bit free-running timer with four channels. Each channel works either as an input capture unit or as an output compare unit. In capture mode the channel latches the running count when its input pin shows the selected transition. In compare mode the channel acts on its output pin when the count equals the channel register. Every channel event and every counter wrap raises a flag. Flags are cleared by writing ones, and each flag can be routed to a single interrupt request line.

Software reaches the block over a byte-wide register bus with an address, write data, a read data return and separate read and write strobes. Reads are combinational in the cycle of the read strobe. Writes, and the side effects of a read, take effect at the rising clock edge.

Register map, with the byte address in brackets:
- count high [0]: a read also copies the count's low byte into a holding byte; a write stores the new high byte in a buffer.
- count low [1]: a read returns the holding byte; a write loads the counter with the buffered high byte and this byte.
- control [2]: bit 0 enables fast overflow clear; bit 1 enables the overflow interrupt.
- mode [3]: bits 3:0 hold the channel modes (1 = compare, 0 = capture); bits 7:4 hold the channel interrupt enables.
- edge [4] and action [5]: two bits per channel, with channel n at bits 2n+1:2n.
- channel flags [6]: bits 3:0.
- overflow flag [7]: bit 7.
- channel n value: high byte at 8+2n and low byte at 9+2n.

Top module: `capcmp_timer`

## Requirements
- R1: Out of reset the counter is 0. It adds one on every clock edge and wraps from 0xFFFF to 0x0000. A write to address 1 loads it with {byte buffered by the last write to address 0, written byte} at that edge.
- R2: A wrap of the count from 0xFFFF to 0x0000 sets bit 7 of address 7. Bits 6:0 of address 7 always read as 0.
- R3: A write to address 6 or 7 clears each flag whose written bit is 1 and leaves each flag whose written bit is 0 unchanged.
- R4: When control bit 0 is 1, any read or write of address 0 or 1 clears the overflow flag. When control bit 0 is 0, such accesses leave the flag unchanged.
- R5: When a flag's set event and a clearing write land on the same edge, the flag ends up set.
- R6: A read of address 0 returns the count's high byte and stores its low byte. A later read of address 1 returns that stored byte, not the live low byte.
- R7: Mode bit n selects compare (1) or capture (0) for channel n. The output pin of a channel in capture mode does not change.
- R8: Edge select codes are 0 = off, 1 = rising, 2 = falling, 3 = either. A selected edge on a capture channel's input latches the count value of that cycle into the channel register and sets channel flag n at the same edge.
- R9: In compare mode, while the count equals the channel value, the next edge sets channel flag n and applies the action code to the pin: 0 = none, 1 = toggle, 2 = drive 0, 3 = drive 1.
- R10: irq is 1 exactly when some flag is set and its enable bit is 1.
- R11: Both bytes of each channel register can be written and read back at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid while rd_en is high |
| cap_in | input | 4 | Channel capture inputs, already synchronous |
| cmp_out | output | 4 | Channel compare output pins |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a counter wrap and a clearing write landing on the same edge. From reset, the stimulus would otherwise have to wait 65536 cycles. The bench loads the counter with 0xFFFE through the two-byte load path, waits one cycle, and then issues the clearing write so that it meets the wrap. Compare matches and captures at exact count values are reached the same way: the bench preloads the counter a few counts below the target and checks the pins on the cycle before and the cycle of the event.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int CH_BASE = 8;

    localparam int A_CNTH  = 0;
    localparam int A_CNTL  = 1;
    localparam int A_CTRL  = 2;
    localparam int A_MODE  = 3;
    localparam int A_EDGE  = 4;
    localparam int A_ACT   = 5;
    localparam int A_CHFLG = 6;
    localparam int A_OVFLG = 7;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;

    typedef struct packed {
        logic  cmp;
        edge_e edge_sel;
        act_e  act;
    } ch_cfg_t;

    function automatic logic edge_hit(edge_e sel, logic prev, logic cur);
        case (sel)
            EDGE_RISE: return !prev && cur;
            EDGE_FALL: return prev && !cur;
            EDGE_ANY:  return prev != cur;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic act_apply(act_e act, logic pin);
        case (act)
            ACT_TOGGLE: return !pin;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return pin;
        endcase
    endfunction

endpackage

// File: rtl/capcmp_counter.sv
module capcmp_counter
    import capcmp_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_we,
    input  logic              load_we,
    input  logic              hi_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CW-1:0]     cnt,
    output logic [BYTE_W-1:0] hold,
    output logic              wrap
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-BYTE_W-1:0] wbuf_q;

    assign wrap = (cnt == CNT_MAX) && !load_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            wbuf_q <= '0;
            hold   <= '0;
        end else begin
            if (buf_we)
                wbuf_q <= wdata[CW-BYTE_W-1:0];
            if (load_we)
                cnt <= {wbuf_q, wdata};
            else
                cnt <= cnt + 1'b1;
            if (hi_rd)
                hold <= cnt[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
    import capcmp_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cnt,
    input  ch_cfg_t           cfg,
    input  logic              pin_in,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CW-1:0]     value,
    output logic              evt,
    output logic              pin_out
);

    logic prev_q;
    logic cap_hit;
    logic cmp_hit;

    assign cap_hit = !cfg.cmp && edge_hit(cfg.edge_sel, prev_q, pin_in);
    assign cmp_hit = cfg.cmp && (cnt == value);
    assign evt     = cap_hit || cmp_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            value   <= '0;
            pin_out <= 1'b0;
        end else begin
            prev_q <= pin_in;
            if (cap_hit) begin
                value <= cnt;
            end else begin
                if (wr_hi)
                    value[CW-1:BYTE_W] <= wdata[CW-BYTE_W-1:0];
                if (wr_lo)
                    value[BYTE_W-1:0] <= wdata;
            end
            if (cmp_hit)
                pin_out <= act_apply(cfg.act, pin_out);
        end
    end

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic [NCH-1:0]    cap_in,
    output logic [NCH-1:0]    cmp_out,
    output logic              irq
);

    localparam int CW = CNT_W;

    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] cnt_hold;
    logic              ovf_evt;
    logic              cnt_load;
    logic              cnt_acc;

    logic              fast_en;
    logic              ovf_ie;
    logic              ovf_flag;
    logic [NCH-1:0]    mode;
    logic [NCH-1:0]    ch_ie;
    logic [NCH-1:0]    ch_flag;
    logic [NCH-1:0]    ch_evt;
    edge_e             edge_q [NCH];
    act_e              act_q  [NCH];
    logic [CW-1:0]     ch_val [NCH];

    function automatic logic hit(logic [AW-1:0] a, int n);
        return a == AW'(n);
    endfunction

    assign cnt_load = wr_en && hit(addr, A_CNTL);
    assign cnt_acc  = (wr_en || rd_en) && (hit(addr, A_CNTH) || hit(addr, A_CNTL));

    capcmp_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .buf_we  (wr_en && hit(addr, A_CNTH)),
        .load_we (cnt_load),
        .hi_rd   (rd_en && hit(addr, A_CNTH)),
        .wdata   (wdata),
        .cnt     (cnt),
        .hold    (cnt_hold),
        .wrap    (ovf_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_cfg_t cfg;
        assign cfg.cmp      = mode[g];
        assign cfg.edge_sel = edge_q[g];
        assign cfg.act      = act_q[g];

        capcmp_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt),
            .cfg     (cfg),
            .pin_in  (cap_in[g]),
            .wr_hi   (wr_en && hit(addr, CH_BASE + 2*g)),
            .wr_lo   (wr_en && hit(addr, CH_BASE + 2*g + 1)),
            .wdata   (wdata),
            .value   (ch_val[g]),
            .evt     (ch_evt[g]),
            .pin_out (cmp_out[g])
        );
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            fast_en <= 1'b0;
            ovf_ie  <= 1'b0;
            mode    <= '0;
            ch_ie   <= '0;
            for (int i = 0; i < NCH; i++) begin
                edge_q[i] <= EDGE_OFF;
                act_q[i]  <= ACT_NONE;
            end
        end else if (wr_en) begin
            if (hit(addr, A_CTRL)) begin
                fast_en <= wdata[0];
                ovf_ie  <= wdata[1];
            end
            if (hit(addr, A_MODE)) begin
                mode  <= wdata[NCH-1:0];
                ch_ie <= wdata[4 +: NCH];
            end
            for (int i = 0; i < NCH; i++) begin
                if (hit(addr, A_EDGE))
                    edge_q[i] <= edge_e'(wdata[2*i +: 2]);
                if (hit(addr, A_ACT))
                    act_q[i] <= act_e'(wdata[2*i +: 2]);
            end
        end
    end

    // flags: a set event wins over a clear on the same edge
    logic [NCH-1:0] ch_clr;
    logic           ovf_clr;

    assign ch_clr  = (wr_en && hit(addr, A_CHFLG)) ? wdata[NCH-1:0] : '0;
    assign ovf_clr = (wr_en && hit(addr, A_OVFLG) && wdata[7]) || (fast_en && cnt_acc);

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_flag  <= '0;
            ovf_flag <= 1'b0;
        end else begin
            ch_flag  <= (ch_flag & ~ch_clr) | ch_evt;
            ovf_flag <= (ovf_flag && !ovf_clr) || ovf_evt;
        end
    end

    assign irq = (ovf_flag && ovf_ie) || |(ch_flag & ch_ie);

    // read mux
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit(addr, A_CNTH)) rdata = cnt[CW-1:BYTE_W];
            if (hit(addr, A_CNTL)) rdata = cnt_hold;
            if (hit(addr, A_CTRL)) rdata = {6'b0, ovf_ie, fast_en};
            if (hit(addr, A_MODE)) begin
                rdata[NCH-1:0]  = mode;
                rdata[4 +: NCH] = ch_ie;
            end
            if (hit(addr, A_CHFLG)) rdata[NCH-1:0] = ch_flag;
            if (hit(addr, A_OVFLG)) rdata[7] = ovf_flag;
            for (int i = 0; i < NCH; i++) begin
                if (hit(addr, A_EDGE)) rdata[2*i +: 2] = edge_q[i];
                if (hit(addr, A_ACT))  rdata[2*i +: 2] = act_q[i];
                if (hit(addr, CH_BASE + 2*i))     rdata = ch_val[i][CW-1:BYTE_W];
                if (hit(addr, CH_BASE + 2*i + 1)) rdata = ch_val[i][BYTE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  addr,
    input logic           rd_en,
    input logic [7:0]     rdata,
    input logic [CW-1:0]  cnt,
    input logic           cnt_load,
    input logic           ovf_flag,
    input logic [NCH-1:0] ch_flag,
    input logic [NCH-1:0] ch_evt,
    input logic [NCH-1:0] mode,
    input logic [NCH-1:0] cmp_out,
    input logic           irq
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        !cnt_load |=> cnt == $past(cnt) + 1'b1);

    assert_wrap_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !cnt_load) |=> ovf_flag);

    assert_ovf_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(7)) |-> rdata[6:0] == 7'd0);

    assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ch_flag & $past(ch_evt)) == $past(ch_evt));

    assert_capture_pin_still_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cmp_out ^ $past(cmp_out)) & ~$past(mode)) == '0);

    assert_flag_needs_event_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ch_flag & ~$past(ch_flag) & ~$past(ch_evt)) == '0);

    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_flag || ch_flag != '0));

endmodule

bind capcmp_timer capcmp_timer_chk #(.NCH(NCH), .AW(AW), .CW(CNT_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .cnt      (cnt),
    .cnt_load (cnt_load),
    .ovf_flag (ovf_flag),
    .ch_flag  (ch_flag),
    .ch_evt   (ch_evt),
    .mode     (mode),
    .cmp_out  (cmp_out),
    .irq      (irq)
);

// File: tb/test_capcmp_timer.sv
module test_capcmp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [3:0] cap_in = '0;
    logic [3:0] cmp_out;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // vector fields: {edge select[1:0], old pin, new pin, expected flag}
    localparam logic [4:0] CAP_VEC [8] = '{
        5'b00_01_0, 5'b00_10_0,
        5'b01_01_1, 5'b01_10_0,
        5'b10_01_0, 5'b10_10_1,
        5'b11_01_1, 5'b11_10_1
    };

    capcmp_timer i_capcmp_timer (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .cap_in  (cap_in),
        .cmp_out (cmp_out),
        .irq     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load_cnt(logic [15:0] v);
        wr(4'd0, v[15:8]);
        wr(4'd1, v[7:0]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] d2;
        cyc(3);
        rst = 1'b0;

        // reset state
        check("R10 irq after reset", irq, 0);
        check("R7 pins after reset", cmp_out, 0);
        rd(4'd7, d); check("R2 ovf flag after reset", d, 8'h00);
        rd(4'd6, d); check("R3 ch flags after reset", d, 8'h00);
        rd(4'd8, d); check("R11 ch0 value after reset", d, 8'h00);

        // R8 capture edge table on channel 0 (capture mode)
        for (int v = 0; v < 8; v++) begin
            cap_in[0] = CAP_VEC[v][2];
            cyc(2);
            wr(4'd4, {6'b0, CAP_VEC[v][4:3]});
            wr(4'd6, 8'h0F);
            cap_in[0] = CAP_VEC[v][1];
            cyc(1);
            rd(4'd6, d);
            check($sformatf("R8 edge vector %0d flag", v), d[0], CAP_VEC[v][0]);
        end
        cap_in[0] = 1'b0;
        wr(4'd4, 8'h00);
        cyc(1);
        wr(4'd6, 8'h0F);

        // R11 channel register write/read back
        wr(4'd14, 8'hA5);
        wr(4'd15, 8'h3C);
        rd(4'd14, d); rd(4'd15, d2);
        check("R11 ch3 readback", {d, d2}, 16'hA53C);

        // R8 captured value on channel 2, rising edge
        wr(4'd4, 8'h10);
        load_cnt(16'h4000);
        cap_in[2] = 1'b1;
        cyc(1);
        rd(4'd12, d); rd(4'd13, d2);
        check("R8 captured count", {d, d2}, 16'h4000);
        rd(4'd6, d); check("R8 ch2 flag", d, 8'h04);
        check("R7 capture pin unchanged", cmp_out, 4'h0);
        wr(4'd6, 8'h0F);

        // R9 compare on channel 1 with toggle, irq enabled for ch1
        wr(4'd3, 8'h22);
        wr(4'd5, 8'h04);
        wr(4'd10, 8'h12);
        wr(4'd11, 8'h33);
        load_cnt(16'h1230);
        cyc(3);
        check("R9 pin before match", cmp_out[1], 1'b0);
        check("R10 irq before match", irq, 1'b0);
        cyc(1);
        check("R9 toggle on match", cmp_out[1], 1'b1);
        check("R10 irq on ch1 flag", irq, 1'b1);
        wr(4'd6, 8'h00);
        rd(4'd6, d); check("R3 zero write keeps flag", d, 8'h02);
        wr(4'd6, 8'h02);
        rd(4'd6, d); check("R3 one write clears flag", d, 8'h00);
        check("R10 irq after clear", irq, 1'b0);

        // R9 clear action
        wr(4'd5, 8'h08);
        load_cnt(16'h1230);
        cyc(4);
        check("R9 clear action", cmp_out[1], 1'b0);
        // R9 set action
        wr(4'd5, 8'h0C);
        load_cnt(16'h1230);
        cyc(4);
        check("R9 set action", cmp_out[1], 1'b1);
        // R9 none action
        wr(4'd5, 8'h00);
        load_cnt(16'h1230);
        cyc(4);
        check("R9 none action keeps pin", cmp_out[1], 1'b1);
        wr(4'd3, 8'h00);
        wr(4'd6, 8'h0F);

        // R2 overflow on wrap
        load_cnt(16'hFFFE);
        cyc(1);
        rd(4'd7, d); check("R2 no flag at FFFF", d, 8'h00);
        rd(4'd7, d); check("R2 flag after wrap", d, 8'h80);
        wr(4'd7, 8'h7F);
        rd(4'd7, d); check("R3 ovf zero bit keeps", d, 8'h80);
        wr(4'd7, 8'h80);
        rd(4'd7, d); check("R3 ovf one clears", d, 8'h00);

        // R5 set beats clear on the same edge
        load_cnt(16'hFFFE);
        cyc(1);
        wr(4'd7, 8'h80);
        rd(4'd7, d); check("R5 wrap wins over clear", d, 8'h80);

        // R4 fast clear disabled: counter read keeps flag
        rd(4'd0, d);
        rd(4'd7, d); check("R4 no fast clear when off", d, 8'h80);
        // R10 overflow interrupt enable
        wr(4'd2, 8'h02);
        check("R10 irq from overflow", irq, 1'b1);
        // R4 fast clear enabled: read clears
        wr(4'd2, 8'h03);
        rd(4'd0, d);
        rd(4'd7, d); check("R4 read clears ovf", d, 8'h00);
        // R4 fast clear by write access
        load_cnt(16'hFFFE);
        cyc(2);
        check("R10 irq ovf again", irq, 1'b1);
        wr(4'd0, 8'h00);
        rd(4'd7, d); check("R4 write clears ovf", d, 8'h00);
        wr(4'd2, 8'h00);

        // R6 coherent count read, R1 load value
        load_cnt(16'h01FE);
        rd(4'd0, d);
        rd(4'd1, d2);
        check("R6 coherent pair", {d, d2}, 16'h01FE);
        rd(4'd0, d);
        check("R1 count advanced past byte", d, 8'h02);

        done = 1'b1;
        finish_run();
    end

endmodule